// File: doc/BRIEF.md
# Burst Column Address Generator

This block sequences the column addresses of read and write bursts for a two-bank synchronous graphics DRAM controller. When a decoded column command arrives, the block captures the start column, the bank, the read/write type and the current mode settings. From the following cycle it presents one column per clock until the burst is over. A burst can be cut short by a new column command or by a stop request, which covers both burst stop and precharge.

The mode inputs set the burst length: 1, 2, 4 or 8 beats, or a full page. They also set the ordering, sequential or interleave, and can enable a mode in which reads burst normally but every write is a single beat. A full-page burst walks through all 256 columns of the row and wraps around. It ends only when it is stopped or replaced. The last-beat flag marks the final beat of fixed-length bursts so that the surrounding controller can schedule its next command.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_out` and `last_out` are low until a command is accepted.
- R2: A command sampled with `cmd_valid` high at a clock edge makes `valid_out` high in the next cycle, with `col_out` equal to the captured start column and `bank_out`/`wr_out` equal to the captured bank and type for the whole burst.
- R3: `mode_len` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Code 7 gives a full page. Codes 4, 5 and 6 give a single beat. `valid_out` drops in the cycle after the final beat unless a new command was accepted.
- R4: With `mode_ilv`=0 and a length L of 2, 4 or 8, beat b presents the start column with its low log2(L) bits replaced by (start + b) mod L. The upper bits are kept.
- R5: With `mode_ilv`=1 and L of 2, 4 or 8, beat b presents the start column with its low log2(L) bits XORed with b. A full-page burst ignores `mode_ilv` and runs sequentially.
- R6: A full-page burst presents (start + b) mod 256. It wraps from 255 to 0, continues without end, and never raises `last_out`.
- R7: `last_out` is high exactly on the final beat of a fixed-length burst.
- R8: `stop_req` sampled high at an edge with no command makes `valid_out` low in the next cycle.
- R9: A command accepted during a running burst makes the next cycle present beat 0 of the new burst. When a command and `stop_req` are sampled at the same edge, the command wins.
- R10: With `mode_wr_single`=1, every write is a single beat with `last_out` high, whatever the programmed length. Reads still use the programmed length.
- R11: Mode inputs are sampled only when a command is accepted. Changing them during a burst does not alter that burst's length or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded read/write column command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 1 | Bank of the command |
| cmd_col | input | 8 | Start column |
| mode_len | input | 3 | Burst length code (see R3) |
| mode_ilv | input | 1 | 1 = interleave order, 0 = sequential |
| mode_wr_single | input | 1 | 1 = writes forced to one beat |
| stop_req | input | 1 | Burst stop or precharge for the running burst |
| col_out | output | 8 | Column of the current beat |
| bank_out | output | 1 | Bank of the current burst |
| wr_out | output | 1 | Type of the current burst |
| valid_out | output | 1 | A beat is presented this cycle |
| last_out | output | 1 | Current beat is the final one |

## Verification
Two events can land on the same clock edge: the arrival of a new command and the end of the running burst, whether that end comes from its final beat or from a stop request. The bench issues a new command on the cycle where an 8-beat burst is mid-way, on the cycle of a final beat, and together with `stop_req`. In each case the next cycle must show beat 0 of the new burst at the new start column, with the new burst's length. The bench also changes the mode inputs right after every command is accepted, so each swept burst shows that its captured settings held.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam int unsigned LEN_CODE_W = 3;
   localparam int unsigned LG_W       = 2;

   localparam logic [LEN_CODE_W-1:0] LEN_CODE_PAGE = 3'd7;

   typedef struct packed {
      logic [LG_W-1:0] lg;
      logic            page;
      logic            ilv;
   } burst_cfg_t;
endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
   import bcg_pkg::*;
(
   input  logic [LEN_CODE_W-1:0] len_code,
   input  logic                  ilv,
   input  logic                  is_write,
   input  logic                  wr_single,
   output burst_cfg_t            cfg
);
   logic force_one;
   assign force_one = is_write && wr_single;

   always_comb begin
      cfg     = '0;
      cfg.ilv = ilv;
      if (!force_one) begin
         if (len_code == LEN_CODE_PAGE) begin
            cfg.page = 1'b1;
         end else if (len_code[LEN_CODE_W-1] == 1'b0) begin
            cfg.lg = len_code[LG_W-1:0];
         end
      end
   end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             stop_req,
   input  burst_cfg_t       cfg_in,
   output logic             active,
   output logic [COL_W-1:0] cnt,
   output burst_cfg_t       cfg_q,
   output logic             last
);
   logic [COL_W-1:0] len_m1;

   generate
      if (COL_W < (1 << LG_W)) begin : g_bad_width
         $error("COL_W too small for the longest fixed burst");
      end
   endgenerate

   assign len_m1 = (COL_W'(1) << cfg_q.lg) - COL_W'(1);
   assign last   = active && !cfg_q.page && (cnt == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         cfg_q  <= '0;
      end else if (cmd_valid) begin
         active <= 1'b1;
         cnt    <= '0;
         cfg_q  <= cfg_in;
      end else if (stop_req) begin
         active <= 1'b0;
      end else if (active) begin
         if (last) active <= 1'b0;
         else      cnt    <= cnt + COL_W'(1);
      end
   end

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !cmd_valid) |=> !active); // R8

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !cmd_valid) |=> !active); // R7

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cfg_q.page) |-> (cnt <= COL_W'(7))); // R3

   AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cfg_q.page && !cmd_valid && !stop_req && (cnt == '1)) |=> (active && cnt == '0)); // R6
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] start_col,
   input  logic [COL_W-1:0] cnt,
   input  burst_cfg_t       cfg,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] mask;
   logic [COL_W-1:0] sum;
   logic             use_xor;

   assign mask    = cfg.page ? '1 : ((COL_W'(1) << cfg.lg) - COL_W'(1));
   assign sum     = start_col + cnt;
   assign use_xor = cfg.ilv && !cfg.page;

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         assign col[i] = mask[i] ? (use_xor ? (start_col[i] ^ cnt[i]) : sum[i])
                                 : start_col[i];
      end
   endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_write,
   input  logic                  cmd_bank,
   input  logic [COL_W-1:0]      cmd_col,
   input  logic [LEN_CODE_W-1:0] mode_len,
   input  logic                  mode_ilv,
   input  logic                  mode_wr_single,
   input  logic                  stop_req,
   output logic [COL_W-1:0]      col_out,
   output logic                  bank_out,
   output logic                  wr_out,
   output logic                  valid_out,
   output logic                  last_out
);
   burst_cfg_t       cfg_new;
   burst_cfg_t       cfg_cur;
   logic [COL_W-1:0] cnt;
   logic [COL_W-1:0] start_q;
   logic             active;
   logic             last;

   bcg_cfg_decode u_dec (
      .len_code  (mode_len),
      .ilv       (mode_ilv),
      .is_write  (cmd_write),
      .wr_single (mode_wr_single),
      .cfg       (cfg_new)
   );

   bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .stop_req  (stop_req),
      .cfg_in    (cfg_new),
      .active    (active),
      .cnt       (cnt),
      .cfg_q     (cfg_cur),
      .last      (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         bank_out <= 1'b0;
         wr_out   <= 1'b0;
      end else if (cmd_valid) begin
         start_q  <= cmd_col;
         bank_out <= cmd_bank;
         wr_out   <= cmd_write;
      end
   end

   bcg_addr_map #(.COL_W(COL_W)) u_map (
      .start_col (start_q),
      .cnt       (cnt),
      .cfg       (cfg_cur),
      .col       (col_out)
   );

   assign valid_out = active;
   assign last_out  = last;

   AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (valid_out && col_out == $past(cmd_col) && bank_out == $past(cmd_bank))); // R2

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && mode_wr_single) |=> last_out); // R10

   AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && !last_out && !cmd_valid && !stop_req) |=>
         (valid_out && $stable(bank_out) && $stable(wr_out))); // R11

   AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      last_out |-> valid_out); // R7
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_bank = 1'b0;
   logic [7:0] cmd_col = '0;
   logic [2:0] mode_len = '0;
   logic       mode_ilv = 1'b0, mode_wr_single = 1'b0, stop_req = 1'b0;
   logic [7:0] col_out;
   logic       bank_out, wr_out, valid_out, last_out;

   int errs = 0;
   int chks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   burst_col_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_bank(cmd_bank), .cmd_col(cmd_col), .mode_len(mode_len),
      .mode_ilv(mode_ilv), .mode_wr_single(mode_wr_single), .stop_req(stop_req),
      .col_out(col_out), .bank_out(bank_out), .wr_out(wr_out),
      .valid_out(valid_out), .last_out(last_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      chks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // effective length: 0 means full page
   function automatic int eff_len(input int code, input bit wr, input bit single);
      if (wr && single) return 1;
      if (code <= 3)    return 1 << code;
      if (code == 7)    return 0;
      return 1;
   endfunction

   function automatic int exp_col(input int s, input int b, input int len, input bit ilv);
      int m;
      if (len == 0) return (s + b) % 256;
      m = len - 1;
      if (ilv) return (s & ~m & 255) | ((s & m) ^ b);
      return (s & ~m & 255) | ((s + b) % len);
   endfunction

   task automatic issue(input int code, input bit ilv, input bit wr, input bit single,
                        input int s, input bit bk);
      cmd_valid = 1; cmd_write = wr; cmd_bank = bk; cmd_col = s[7:0];
      mode_len = code[2:0]; mode_ilv = ilv; mode_wr_single = single;
      @(negedge clk);
      cmd_valid = 0;
      // R11: disturb mode right after acceptance
      mode_len = code[2:0] ^ 3'b101; mode_ilv = ~ilv; mode_wr_single = ~single;
   endtask

   // checks beats first..nb-1 of a burst; leaves sim at negedge after last checked beat
   task automatic beats(input int s, input int len, input bit ilv, input bit bk,
                        input bit wr, input int first, input int nb);
      string ctag;
      ctag = (len == 0) ? "R6" : ((len == 1) ? "R3" : (ilv ? "R5" : "R4"));
      for (int b = first; b < nb; b++) begin
         chk(valid_out === 1'b1, "R3 valid", int'(valid_out), 1);
         chk(col_out == exp_col(s, b, len, ilv)[7:0], ctag, int'(col_out), exp_col(s, b, len, ilv));
         chk(last_out == ((len != 0) && (b == len - 1)), (len == 0) ? "R6 last" : "R7 last",
             int'(last_out), int'((len != 0) && (b == len - 1)));
         if (b == first) begin
            chk(bank_out == bk && wr_out == wr, "R2 bank/type", int'({bank_out, wr_out}), int'({bk, wr}));
         end
         if (b != nb - 1) @(negedge clk);
      end
   endtask

   task automatic full_burst(input int code, input bit ilv, input bit wr, input bit single,
                             input int s, input bit bk);
      int len;
      len = eff_len(code, wr, single);
      issue(code, ilv, wr, single, s, bk);
      if (len == 0) begin
         beats(s, 0, ilv, bk, wr, 0, 260);
         stop_req = 1;
         @(negedge clk);
         stop_req = 0;
         chk(valid_out === 1'b0, "R8 stop", int'(valid_out), 0);
      end else begin
         beats(s, len, ilv, bk, wr, 0, len);
         @(negedge clk);
         chk(valid_out === 1'b0, "R3 end", int'(valid_out), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; chks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   end

   initial begin
      int starts[5] = '{0, 3, 5, 254, 123};
      repeat (3) @(negedge clk);
      chk(valid_out === 1'b0 && last_out === 1'b0, "R1 reset", int'({valid_out, last_out}), 0);
      rst_n = 1;
      @(negedge clk);
      chk(valid_out === 1'b0, "R1 idle", int'(valid_out), 0);

      // sweep of lengths, orders, start columns (reads)
      for (int code = 0; code < 8; code++)
         for (int il = 0; il < 2; il++)
            for (int k = 0; k < 5; k++)
               full_burst(code, il[0], 1'b0, 1'b0, starts[k], k[0]);

      // R10: writes single beat in write-single mode, reads unaffected
      full_burst(3, 1'b0, 1'b1, 1'b1, 8'h2A, 1'b1);
      full_burst(7, 1'b0, 1'b1, 1'b1, 8'h91, 1'b0);
      full_burst(3, 1'b1, 1'b0, 1'b1, 8'h2A, 1'b1);
      full_burst(2, 1'b0, 1'b1, 1'b0, 8'h17, 1'b0);

      // R9: interrupt an 8-beat burst mid-way
      issue(3, 1'b0, 1'b0, 1'b0, 8'h16, 1'b0);
      beats(8'h16, 8, 1'b0, 1'b0, 1'b0, 0, 3);
      issue(2, 1'b1, 1'b1, 1'b0, 8'h45, 1'b1);
      chk(col_out == 8'h45, "R9 interrupt", int'(col_out), 8'h45);
      beats(8'h45, 4, 1'b1, 1'b1, 1'b1, 0, 4);
      // R9: new command on the final beat -> seamless
      issue(1, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0);
      beats(8'h81, 2, 1'b0, 1'b0, 1'b0, 0, 2);
      @(negedge clk);
      chk(valid_out === 1'b0, "R3 end", int'(valid_out), 0);

      // R9: command and stop at the same edge -> command wins
      issue(7, 1'b0, 1'b0, 1'b0, 8'hF0, 1'b0);
      beats(8'hF0, 0, 1'b0, 1'b0, 1'b0, 0, 20);
      stop_req = 1;
      issue(3, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b1);
      stop_req = 0;
      chk(valid_out === 1'b1 && col_out == 8'h0B, "R9 cmd+stop", int'(col_out), 8'h0B);
      beats(8'h0B, 8, 1'b1, 1'b1, 1'b0, 0, 8);
      @(negedge clk);
      chk(valid_out === 1'b0, "R3 end", int'(valid_out), 0);

      // R8: stop a fixed burst early
      issue(3, 1'b0, 1'b0, 1'b0, 8'h30, 1'b0);
      beats(8'h30, 8, 1'b0, 1'b0, 1'b0, 0, 2);
      stop_req = 1;
      @(negedge clk);
      stop_req = 0;
      chk(valid_out === 1'b0, "R8 early stop", int'(valid_out), 0);
      @(negedge clk);
      chk(valid_out === 1'b0, "R8 stays idle", int'(valid_out), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end
endmodule